// File: doc/BRIEF.md
# Multicast One-Place Event Channel

This block is one communication net between a single producer and a fixed number of consumers. Every consumer has its own one-deep slot, made of a pending-event flag and a data word. The producer has two independent actions. A data write stores a word in every consumer's slot. An emit raises the pending flag in every slot. Neither action ever stalls. Each consumer takes its event on its own schedule by pulsing its consume line, which drops only its own flag.

Event and data travel on separate paths. A data write that lands after an emit but before a consumer reads the word replaces the word, and the pending event stays in place. A second emit that reaches a consumer whose flag is still up loses the earlier event. The block signals each such loss per consumer with a one-cycle pulse and adds it to a per-consumer loss counter. A parameter selects whether that counter saturates or wraps.

Top module: `evnet_multicast`

## Requirements
- R1: While `rst` is high at a rising edge, every pending flag, data word, loss pulse and loss counter is zero after that edge.
- R2: An emit sets the pending flag of every consumer at the next edge.
- R3: A consume pulse without a simultaneous emit clears only that consumer's flag at the next edge, and the other consumers' flags are unchanged.
- R4: With no emit and no consume, a consumer's flag keeps its value.
- R5: When emit and consume for the same consumer arrive in the same cycle, the flag is 1 after the edge and no loss is reported for that consumer.
- R6: An emit that reaches a consumer whose flag is 1 and that is not consuming in that cycle raises that consumer's loss pulse for exactly the following cycle and adds one to its loss counter. The flag stays 1.
- R7: A data write stores `wr_data` in every consumer's data word at the next edge, whatever the flags are, and leaves the flags unchanged. A word can therefore be replaced under a pending event.
- R8: A consume pulse for a consumer whose flag is 0 changes nothing for that consumer and reports no loss.
- R9: In saturating mode (default) a loss counter that holds its maximum value 2^CNT_W-1 stays at that value on further losses.
- R10: Emit and consume never change a data word. Only data writes and reset do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Producer data write strobe |
| wr_data | input | DATA_W | Word written to every consumer slot |
| emit | input | 1 | Producer event emission |
| consume | input | N_RX | Per-consumer consume strobe, bit i for consumer i |
| present | output | N_RX | Per-consumer pending-event flag |
| rx_data | output | N_RX*DATA_W | Consumer data words, consumer i in bits [i*DATA_W +: DATA_W] |
| ovf_pulse | output | N_RX | One-cycle lost-event pulse per consumer |
| ovf_count | output | N_RX*CNT_W | Loss counters, consumer i in bits [i*CNT_W +: CNT_W] |

## Verification
A wrong flag in any slot shows on `present` one edge after the stimulus that caused it. It also shows one edge after the next emit, either as a loss pulse that is missing or one that should not be there, and that error stays in the counter for the rest of the run. A stale or wrongly routed data word shows on `rx_data` one edge after a write. The bench compares every consumer's word after every step, so an error confined to one consumer is caught within a cycle. The same-cycle emit-and-consume case is exercised on purpose, because there a priority inverted between the two actions would clear the flag and report a false loss.

// File: rtl/evnet_pkg.sv
package evnet_pkg;

   typedef enum logic {
      CNT_WRAP     = 1'b0,
      CNT_SATURATE = 1'b1
   } cnt_mode_e;

endpackage

// File: rtl/evnet_slot.sv
module evnet_slot #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              emit,
   input  logic              consume,
   output logic              present,
   output logic [DATA_W-1:0] data,
   output logic              ovf_pulse,
   output logic              ovf_hit
);

   logic flag_q;
   logic flag_d;
   logic [DATA_W-1:0] data_q;
   logic ovf_q;

   initial begin : elab_chk
      assert (DATA_W >= 1) else $fatal(1, "evnet_slot: DATA_W must be at least 1");
   end

   // loss: an event is pending, another arrives, and this cycle does not consume
   always_comb begin
      ovf_hit = emit & flag_q & ~consume;
      if (emit)
         flag_d = 1'b1;
      else if (consume)
         flag_d = 1'b0;
      else
         flag_d = flag_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= 1'b0;
         data_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         flag_q <= flag_d;
         ovf_q  <= ovf_hit;
         if (wr_en)
            data_q <= wr_data;
      end
   end

   assign present   = flag_q;
   assign data      = data_q;
   assign ovf_pulse = ovf_q;

   p_emit_sets_r2: assert property (@(posedge clk) disable iff (rst)
      emit |=> present);
   p_consume_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (consume && !emit) |=> !present);
   p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!consume && !emit) |=> $stable(present));
   p_same_cycle_r5: assert property (@(posedge clk) disable iff (rst)
      (emit && consume) |=> (present && !ovf_pulse));
   p_loss_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      (emit && present && !consume) |=> ovf_pulse);
   p_no_loss_r6: assert property (@(posedge clk) disable iff (rst)
      (!emit || !present) |=> !ovf_pulse);
   p_data_write_r7: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (data == $past(wr_data)));
   p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(data));

endmodule

// File: rtl/evnet_ovf_cnt.sv
module evnet_ovf_cnt
   import evnet_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter cnt_mode_e   MODE  = CNT_SATURATE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   initial begin : elab_chk
      assert (CNT_W >= 1 && CNT_W <= 32) else $fatal(1, "evnet_ovf_cnt: CNT_W out of range");
   end

   generate
      if (MODE == CNT_SATURATE) begin : g_sat
         always_comb begin
            if (inc && cnt_q != CNT_MAX)
               cnt_d = cnt_q + 1'b1;
            else
               cnt_d = cnt_q;
         end

         p_cnt_sat_r9: assert property (@(posedge clk) disable iff (rst)
            (inc && count == CNT_MAX) |=> (count == CNT_MAX));
      end else begin : g_wrap
         always_comb begin
            if (inc)
               cnt_d = cnt_q + 1'b1;
            else
               cnt_d = cnt_q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   assign count = cnt_q;

   p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
      (inc && count != CNT_MAX) |=> (count == CNT_W'($past(count) + 1'b1)));
   p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(count));

endmodule

// File: rtl/evnet_multicast.sv
module evnet_multicast
   import evnet_pkg::*;
#(
   parameter int unsigned N_RX   = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 8,
   parameter cnt_mode_e   MODE   = CNT_SATURATE
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     emit,
   input  logic [N_RX-1:0]          consume,
   output logic [N_RX-1:0]          present,
   output logic [N_RX*DATA_W-1:0]   rx_data,
   output logic [N_RX-1:0]          ovf_pulse,
   output logic [N_RX*CNT_W-1:0]    ovf_count
);

   localparam int unsigned DATA_BITS = N_RX * DATA_W;
   localparam int unsigned CNT_BITS  = N_RX * CNT_W;

   logic [N_RX-1:0] hit;

   initial begin : elab_chk
      assert (N_RX >= 1 && N_RX <= 256) else $fatal(1, "evnet_multicast: N_RX out of range");
      assert (DATA_BITS >= DATA_W && CNT_BITS >= CNT_W) else $fatal(1, "evnet_multicast: width mismatch");
   end

   generate
      for (genvar i = 0; i < N_RX; i++) begin : g_rx
         evnet_slot #(
            .DATA_W (DATA_W)
         ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_en),
            .wr_data   (wr_data),
            .emit      (emit),
            .consume   (consume[i]),
            .present   (present[i]),
            .data      (rx_data[i*DATA_W +: DATA_W]),
            .ovf_pulse (ovf_pulse[i]),
            .ovf_hit   (hit[i])
         );

         evnet_ovf_cnt #(
            .CNT_W (CNT_W),
            .MODE  (MODE)
         ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (hit[i]),
            .count (ovf_count[i*CNT_W +: CNT_W])
         );
      end
   endgenerate

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (present == '0 && ovf_pulse == '0 && rx_data == '0 && ovf_count == '0));
   p_multicast_r2: assert property (@(posedge clk) disable iff (rst)
      emit |=> (present == {N_RX{1'b1}}));
   p_idle_consume_r8: assert property (@(posedge clk) disable iff (rst)
      (!emit) |=> (ovf_pulse == '0));
   p_write_flags_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !emit && consume == '0) |=> $stable(present));

endmodule

// File: tb/evnet_multicast_bench.sv
module evnet_multicast_bench;
   import evnet_pkg::*;

   localparam int N  = 4;
   localparam int DW = 8;
   localparam int CW = 3;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic            clk = 1'b0;
   logic            rst;
   logic            wr_en;
   logic [DW-1:0]   wr_data;
   logic            emit;
   logic [N-1:0]    consume;
   logic [N-1:0]    present;
   logic [N*DW-1:0] rx_data;
   logic [N-1:0]    ovf_pulse;
   logic [N*CW-1:0] ovf_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DW-1:0] m_data;
   logic [CW-1:0] m_cnt [N];

   always #5 clk = ~clk;

   evnet_multicast #(
      .N_RX   (N),
      .DATA_W (DW),
      .CNT_W  (CW),
      .MODE   (CNT_SATURATE)
   ) u_evnet_multicast (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .emit      (emit),
      .consume   (consume),
      .present   (present),
      .rx_data   (rx_data),
      .ovf_pulse (ovf_pulse),
      .ovf_count (ovf_count)
   );

   // {wr_en, wr_data, emit, consume, exp_present, exp_ovf}
   localparam int NV = 10;
   localparam logic [21:0] VEC [NV] = '{
      {1'b1, 8'hA5, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R7 write, no event
      {1'b0, 8'h00, 1'b1, 4'b0000, 4'b1111, 4'b0000}, // R2 multicast emit
      {1'b1, 8'h3C, 1'b0, 4'b0000, 4'b1111, 4'b0000}, // R7 replace under pending event
      {1'b0, 8'h00, 1'b1, 4'b0001, 4'b1111, 4'b1110}, // R5 rx0 same cycle, R6 others lose
      {1'b0, 8'h00, 1'b0, 4'b0010, 4'b1101, 4'b0000}, // R3 rx1 only
      {1'b0, 8'h00, 1'b0, 4'b0010, 4'b1101, 4'b0000}, // R8 consume while empty
      {1'b0, 8'h00, 1'b1, 4'b0000, 4'b1111, 4'b1101}, // R6 loss where pending
      {1'b0, 8'h00, 1'b0, 4'b1111, 4'b0000, 4'b0000}, // R3 all consume
      {1'b0, 8'h00, 1'b1, 4'b1111, 4'b1111, 4'b0000}, // R5 emit wins on empty flags
      {1'b1, 8'h77, 1'b1, 4'b0000, 4'b1111, 4'b1111}  // R6 + R7 together
   };

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_state(input string req, input logic [N-1:0] ep, input logic [N-1:0] eo);
      check(req, "present", 64'(present), 64'(ep));
      check(req, "ovf_pulse", 64'(ovf_pulse), 64'(eo));
      for (int i = 0; i < N; i++) begin
         check(req, "rx_data", 64'(rx_data[i*DW +: DW]), 64'(m_data));
         check(req, "ovf_count", 64'(ovf_count[i*CW +: CW]), 64'(m_cnt[i]));
      end
   endtask

   task automatic step(input logic w, input logic [DW-1:0] d, input logic e, input logic [N-1:0] c);
      wr_en = w; wr_data = d; emit = e; consume = c;
      @(negedge clk);
      if (w) m_data = d;
   endtask

   task automatic count_loss(input logic [N-1:0] eo);
      for (int i = 0; i < N; i++)
         if (eo[i] && m_cnt[i] != CMAX) m_cnt[i] = m_cnt[i] + 1'b1;
   endtask

   task automatic model_reset();
      m_data = '0;
      for (int i = 0; i < N; i++) m_cnt[i] = '0;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_data = '0; emit = 1'b0; consume = '0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      check_state("R1", '0, '0);
      rst = 1'b0;

      for (int v = 0; v < NV; v++) begin
         step(VEC[v][21], VEC[v][20:13], VEC[v][12], VEC[v][11:8]);
         count_loss(VEC[v][3:0]);
         check_state($sformatf("R2-7 row%0d", v), VEC[v][7:4], VEC[v][3:0]);
      end

      // R4: hold with idle inputs for several cycles
      for (int k = 0; k < 3; k++) begin
         step(1'b0, '0, 1'b0, '0);
         check_state("R4", '1, '0);
      end

      // R10: consume does not disturb data
      step(1'b0, 8'hFF, 1'b0, 4'b0101);
      check_state("R10", 4'b1010, '0);
      step(1'b0, '0, 1'b1, 4'b0000);
      count_loss(4'b1010);
      check_state("R6", '1, 4'b1010);

      // R9: drive losses until counters saturate, then once more
      for (int k = 0; k < 9; k++) begin
         step(1'b0, '0, 1'b1, '0);
         count_loss('1);
         check_state("R9", '1, '1);
      end
      for (int i = 0; i < N; i++)
         check("R9", "saturated", 64'(ovf_count[i*CW +: CW]), 64'(CMAX));

      // R1: reset mid-run
      rst = 1'b1;
      step(1'b1, 8'h5A, 1'b1, '0);
      model_reset();
      check_state("R1", '0, '0);
      rst = 1'b0;
      step(1'b0, '0, 1'b0, '0);
      check_state("R1", '0, '0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule